// File: doc/BRIEF.md
# Dual-Phase Oversampled Frame Validator

This block receives a single serial line that carries data with no accompanying clock. The line is sampled at twice the bit rate: one sample per clock, where the clock runs at twice the nominal bit rate. Samples are dealt alternately into two bit streams. Stream A takes the even samples and stream B takes the odd ones, so B lags A by half a bit. The block never estimates where the bit centres lie. Instead it decodes both streams in full and lets the frame checksum decide which one sampled cleanly.

Each stream has its own 32-bit sync search. When the search matches, that stream captures a payload and a checksum and verifies the checksum itself. An arbiter gathers the results of the streams that joined the same frame and makes the decision:

- If exactly one stream passes, the block reports that stream.
- If both pass and their payloads agree, the block reports stream A.
- If both pass but their payloads disagree, the block rejects the frame.
- If no stream passes, the block rejects the frame.

A trigger pulse marks the first sync match of each frame. The input synchronizer sits upstream of this block.

Top module: `dual_phase_frame_validator`

## Requirements
- R1: While reset is asserted, and on leaving reset, sync_trig, frame_valid and frame_bad are 0, payload is all zeros and sel_phase is 0.
- R2: The first sample after reset belongs to stream A. After that, samples alternate strictly between streams: even samples go to A and odd samples go to B.
- R3: A stream arms when its last 32 received bits equal the sync pattern, with the oldest bit compared to the pattern MSB. sync_trig pulses once per frame, in the cycle of the first stream's match.
- R4: After a match, the stream takes the next 152 bits as payload, with the first bit landing in payload[151]. It then takes 16 checksum bits, MSB first. Its search is suspended for those 168 bits, so a copy of the pattern inside the payload starts nothing.
- R5: The checksum is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It is run MSB first over the 152 payload bits only, with no reflection and no final XOR. A frame whose checksum was made with start value 0 fails.
- R6: When both streams joined the frame, both pass, and the payloads are equal, frame_valid pulses with that payload and sel_phase=0.
- R7: When exactly one joined stream passes, frame_valid pulses with that stream's payload. sel_phase is 0 for A and 1 for B.
- R8: When both joined streams pass but their payloads differ, frame_bad pulses and frame_valid does not.
- R9: When no joined stream passes, frame_bad pulses.
- R10: The second stream joins a frame only if its match comes at most 4 samples (2 bit times) after the first stream's match. A later match is left out of that frame's decision.
- R11: A line on which neither stream finds the pattern produces no sync_trig, frame_valid or frame_bad.
- R12: Each frame yields exactly one single-cycle pulse, on either frame_valid or frame_bad. payload and sel_phase change only with frame_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_smp | input | 1 | Synchronized line sample |
| sync_trig | output | 1 | Pulse on the first sync match of a frame |
| frame_valid | output | 1 | One-cycle pulse: accepted frame |
| frame_bad | output | 1 | One-cycle pulse: rejected frame |
| payload | output | 152 | Payload of the last accepted frame |
| sel_phase | output | 1 | Stream that supplied the payload (0 = A, 1 = B) |

## Verification
The bench feeds each stream its own bit sequence, so the two phases can carry different content. This lets it place the second stream's match exactly 3 or 5 samples after the first. A window that is off by one sample would then join the wrong stream, and a frame that should be rejected for disagreement would come out as accepted, or the reverse.

Corruption is aimed at one phase at a time. A flip in the sync field, the payload or the checksum shows whether the design falls back to the clean phase and reports the right sel_phase. Other frames carry a copy of the pattern inside the payload, or a checksum built with the wrong start value. A design that kept searching during capture would emit two results, and one with the wrong start value would accept bad frames.

// File: rtl/dpfv_pkg.sv
package dpfv_pkg;

   localparam int unsigned CRC_W = 16;

   typedef enum logic {
      RX_SEARCH  = 1'b0,
      RX_CAPTURE = 1'b1
   } rx_state_e;

   // One MSB-first step of a 16-bit CRC shift register
   function automatic logic [CRC_W-1:0] crc_step(
      input logic [CRC_W-1:0] cur,
      input logic             din,
      input logic [CRC_W-1:0] poly
   );
      logic fb;
      fb = cur[CRC_W-1] ^ din;
      return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
   endfunction

endpackage

// File: rtl/dpfv_phase_split.sv
module dpfv_phase_split (
   input  logic       clk,
   input  logic       rst_n,
   output logic [1:0] take
);
   logic odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) odd_q <= 1'b0;
      else        odd_q <= ~odd_q;
   end

   assign take[0] = ~odd_q;
   assign take[1] = odd_q;

   // R2: a stream-A sample is always followed by a stream-B sample
   assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take[0] |=> take[1]);

endmodule

// File: rtl/dpfv_stream_rx.sv
module dpfv_stream_rx
   import dpfv_pkg::*;
#(
   parameter int unsigned            SYNC_W   = 32,
   parameter logic [SYNC_W-1:0]      SYNC_PAT = 32'hB5C3_96E1,
   parameter int unsigned            PAY_W    = 152,
   parameter logic [CRC_W-1:0]       CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0]       CRC_INIT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             bit_in,
   output logic             hit,
   output logic             done,
   output logic             crc_ok,
   output logic [PAY_W-1:0] pay
);
   localparam int unsigned BODY_W = PAY_W + CRC_W;
   localparam int unsigned CNT_W  = $clog2(BODY_W + 1);
   localparam logic [CNT_W-1:0] CNT_PAY = CNT_W'(PAY_W);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BODY_W - 1);

   rx_state_e         st;
   logic [SYNC_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic [CRC_W-1:0]  crc_c;
   logic [CRC_W-1:0]  crc_r;

   logic [SYNC_W-1:0] sh_nx;
   logic [CRC_W-1:0]  crc_r_nx;
   assign sh_nx    = {sh[SYNC_W-2:0], bit_in};
   assign crc_r_nx = {crc_r[CRC_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RX_SEARCH;
         sh     <= '0;
         cnt    <= '0;
         crc_c  <= CRC_INIT;
         crc_r  <= '0;
         pay    <= '0;
         hit    <= 1'b0;
         done   <= 1'b0;
         crc_ok <= 1'b0;
      end else begin
         hit  <= 1'b0;
         done <= 1'b0;
         if (take) begin
            if (st == RX_SEARCH) begin
               if (sh_nx == SYNC_PAT) begin
                  st    <= RX_CAPTURE;
                  sh    <= '0;
                  cnt   <= '0;
                  crc_c <= CRC_INIT;
                  hit   <= 1'b1;
               end else begin
                  sh <= sh_nx;
               end
            end else begin
               cnt <= cnt + CNT_W'(1);
               if (cnt < CNT_PAY) begin
                  pay   <= {pay[PAY_W-2:0], bit_in};
                  crc_c <= crc_step(crc_c, bit_in, CRC_POLY);
               end else begin
                  crc_r <= crc_r_nx;
               end
               if (cnt == CNT_END) begin
                  st     <= RX_SEARCH;
                  done   <= 1'b1;
                  crc_ok <= (crc_r_nx == crc_c);
               end
            end
         end
      end
   end

   // R4: a completion only follows a capture in progress
   assert_done_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(st == RX_CAPTURE));

   // R4: a capture that just started is not restarted by a second match
   assert_no_rehit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

endmodule

// File: rtl/dpfv_arbiter.sv
module dpfv_arbiter #(
   parameter int unsigned PAY_W = 152,
   parameter int unsigned WIN   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       hit,
   input  logic [1:0]       done,
   input  logic [1:0]       ok,
   input  logic [PAY_W-1:0] pay_a,
   input  logic [PAY_W-1:0] pay_b,
   output logic             sync_trig,
   output logic             frame_valid,
   output logic             frame_bad,
   output logic [PAY_W-1:0] payload,
   output logic             sel_phase
);
   localparam int unsigned WC_W = $clog2(WIN + 1);

   logic [1:0]      pend;
   logic [1:0]      dn;
   logic [1:0]      okl;
   logic [WC_W-1:0] win;

   logic       idle;
   logic [1:0] dn_nx;
   logic [1:0] ok_nx;
   logic       ready;

   assign idle      = (pend == 2'b00);
   assign sync_trig = idle & (|hit);
   assign dn_nx     = dn  | (done & pend);
   assign ok_nx     = okl | (done & pend & ok);
   assign ready     = !idle && ((win == '0) || (pend == 2'b11)) && ((dn_nx & pend) == pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend        <= '0;
         dn          <= '0;
         okl         <= '0;
         win         <= '0;
         frame_valid <= 1'b0;
         frame_bad   <= 1'b0;
         payload     <= '0;
         sel_phase   <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         frame_bad   <= 1'b0;
         if (idle) begin
            if (|hit) begin
               pend <= hit;
               dn   <= '0;
               okl  <= '0;
               win  <= (hit == 2'b11) ? '0 : WC_W'(WIN);
            end
         end else if (ready) begin
            pend <= '0;
            win  <= '0;
            if (ok_nx == 2'b11) begin
               if (pay_a == pay_b) begin
                  frame_valid <= 1'b1;
                  payload     <= pay_a;
                  sel_phase   <= 1'b0;
               end else begin
                  frame_bad <= 1'b1;
               end
            end else if (ok_nx[0]) begin
               frame_valid <= 1'b1;
               payload     <= pay_a;
               sel_phase   <= 1'b0;
            end else if (ok_nx[1]) begin
               frame_valid <= 1'b1;
               payload     <= pay_b;
               sel_phase   <= 1'b1;
            end else begin
               frame_bad <= 1'b1;
            end
         end else begin
            dn  <= dn_nx;
            okl <= ok_nx;
            if (win != '0) begin
               win  <= win - WC_W'(1);
               pend <= pend | hit;
            end
         end
      end
   end

   assert_single_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && frame_bad));

   assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   // R10: once the window has closed, no new stream joins the frame
   assert_window_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && win == '0) |=> (pend == 2'b00 || $stable(pend)));

   assert_trig_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_trig |=> (pend != 2'b00));

   // R12: payload only moves together with an accept pulse
   assert_payload_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable(payload));

endmodule

// File: rtl/dual_phase_frame_validator.sv
module dual_phase_frame_validator
   import dpfv_pkg::*;
#(
   parameter int unsigned        SYNC_W   = 32,
   parameter logic [SYNC_W-1:0]  SYNC_PAT = 32'hB5C3_96E1,
   parameter int unsigned        PAY_W    = 152,
   parameter logic [CRC_W-1:0]   CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0]   CRC_INIT = 16'hFFFF,
   parameter int unsigned        WIN_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_smp,
   output logic             sync_trig,
   output logic             frame_valid,
   output logic             frame_bad,
   output logic [PAY_W-1:0] payload,
   output logic             sel_phase
);
   localparam int unsigned N_PH = 2;
   localparam int unsigned WIN  = WIN_BITS * N_PH;

   if (SYNC_W < 2 || PAY_W < 2 || WIN_BITS < 1) begin : g_param_check
      $error("dual_phase_frame_validator: SYNC_W and PAY_W must be >= 2, WIN_BITS >= 1");
   end

   logic [N_PH-1:0] take;
   logic [N_PH-1:0] hit;
   logic [N_PH-1:0] done;
   logic [N_PH-1:0] ok;
   logic [PAY_W-1:0] pay_s [N_PH];

   dpfv_phase_split u_split (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take)
   );

   for (genvar p = 0; p < N_PH; p++) begin : g_phase
      dpfv_stream_rx #(
         .SYNC_W   (SYNC_W),
         .SYNC_PAT (SYNC_PAT),
         .PAY_W    (PAY_W),
         .CRC_POLY (CRC_POLY),
         .CRC_INIT (CRC_INIT)
      ) u_rx (
         .clk    (clk),
         .rst_n  (rst_n),
         .take   (take[p]),
         .bit_in (line_smp),
         .hit    (hit[p]),
         .done   (done[p]),
         .crc_ok (ok[p]),
         .pay    (pay_s[p])
      );
   end

   dpfv_arbiter #(
      .PAY_W (PAY_W),
      .WIN   (WIN)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .done        (done),
      .ok          (ok),
      .pay_a       (pay_s[0]),
      .pay_b       (pay_s[1]),
      .sync_trig   (sync_trig),
      .frame_valid (frame_valid),
      .frame_bad   (frame_bad),
      .payload     (payload),
      .sel_phase   (sel_phase)
   );

endmodule

// File: tb/sim_dual_phase_frame_validator.sv
module sim_dual_phase_frame_validator;

   localparam int unsigned PAY_W = 152;
   localparam int unsigned FR_W  = 200;
   localparam int unsigned NB    = 260;
   localparam logic [31:0] PAT   = 32'hB5C3_96E1;

   typedef struct {
      bit              en;
      int              off;
      logic [PAY_W-1:0] pay;
      int              flip;
      bit              bad_init;
   } scfg_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_smp = 1'b0;
   logic sync_trig, frame_valid, frame_bad, sel_phase;
   logic [PAY_W-1:0] payload;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   logic sa [NB];
   logic sb [NB];
   logic [PAY_W-1:0] last_pay = '0;
   logic             last_sel = 1'b0;

   always #5 clk = ~clk;

   dual_phase_frame_validator u0 (
      .clk(clk), .rst_n(rst_n), .line_smp(line_smp),
      .sync_trig(sync_trig), .frame_valid(frame_valid), .frame_bad(frame_bad),
      .payload(payload), .sel_phase(sel_phase)
   );

   task automatic chk(input string tag, input string what,
                      input logic [PAY_W-1:0] act, input logic [PAY_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [PAY_W-1:0] p, input logic [15:0] init);
      logic [15:0] c;
      c = init;
      for (int i = PAY_W - 1; i >= 0; i--) begin
         if (c[15] ^ p[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
         else              c = {c[14:0], 1'b0};
      end
      return c;
   endfunction

   function automatic logic [PAY_W-1:0] rnd_pay();
      return PAY_W'({$urandom(), $urandom(), $urandom(), $urandom(), $urandom()});
   endfunction

   task automatic build(input bit which, input scfg_t c);
      logic [FR_W-1:0] fr;
      for (int i = 0; i < NB; i++) begin
         if (which) sb[i] = 1'b0; else sa[i] = 1'b0;
      end
      if (c.en) begin
         fr = {PAT, c.pay, ref_crc(c.pay, c.bad_init ? 16'h0000 : 16'hFFFF)};
         if (c.flip >= 0) fr[FR_W-1-c.flip] = ~fr[FR_W-1-c.flip];
         for (int j = 0; j < FR_W; j++) begin
            if (which) sb[c.off + j] = fr[FR_W-1-j];
            else       sa[c.off + j] = fr[FR_W-1-j];
         end
      end
   endtask

   // Expected outcome from R3, R6-R11
   task automatic predict(input scfg_t a, input scfg_t b,
                          output bit any, output bit v,
                          output logic [PAY_W-1:0] p, output bit s);
      bit ha, hb, pa, pb, oka, okb;
      int ta, tb;
      ha = a.en && !(a.flip >= 0 && a.flip < 32);
      hb = b.en && !(b.flip >= 0 && b.flip < 32);
      ta = 2 * (a.off + 31);
      tb = 2 * (b.off + 31) + 1;
      pa = ha; pb = hb;
      if (ha && hb) begin
         if (ta < tb) pb = (tb - ta) <= 4;
         else         pa = (ta - tb) <= 4;
      end
      oka = pa && (a.flip < 0) && !a.bad_init;
      okb = pb && (b.flip < 0) && !b.bad_init;
      any = ha || hb;
      v = 0; p = '0; s = 0;
      if (oka && okb) begin
         if (a.pay == b.pay) begin v = 1; p = a.pay; s = 0; end
      end else if (oka) begin v = 1; p = a.pay; s = 0; end
      else if (okb) begin v = 1; p = b.pay; s = 1; end
   endtask

   task automatic run_case(input string tag, input scfg_t a, input scfg_t b);
      int nv, nbd, nt;
      logic [PAY_W-1:0] got_pay;
      logic got_sel;
      bit any, v, s;
      logic [PAY_W-1:0] p;
      nv = 0; nbd = 0; nt = 0; got_pay = '0; got_sel = 0;
      build(1'b0, a);
      build(1'b1, b);
      predict(a, b, any, v, p, s);
      for (int i = 0; i < NB + 10; i++) begin
         for (int h = 0; h < 2; h++) begin
            if (i < NB) line_smp = h ? sb[i] : sa[i];
            else        line_smp = 1'b0;
            @(negedge clk);
            if (sync_trig) nt++;
            if (frame_bad) nbd++;
            if (frame_valid) begin nv++; got_pay = payload; got_sel = sel_phase; end
         end
      end
      if (!any) begin
         chk({tag, " R11"}, "pulses", PAY_W'(nv + nbd + nt), '0);
      end else begin
         chk({tag, " R3"}, "trig count", PAY_W'(nt), PAY_W'(1));
         chk({tag, " R12"}, "verdict count", PAY_W'(nv + nbd), PAY_W'(1));
         chk({tag, " R12"}, "valid count", PAY_W'(nv), PAY_W'(v));
         if (v) begin
            chk(tag, "payload", got_pay, p);
            chk(tag, "sel_phase", PAY_W'(got_sel), PAY_W'(s));
            last_pay = p; last_sel = s;
         end
      end
      chk({tag, " R12"}, "held payload", payload, last_pay);
      chk({tag, " R12"}, "held sel", PAY_W'(sel_phase), PAY_W'(last_sel));
   endtask

   function automatic scfg_t mk(input int off, input logic [PAY_W-1:0] p, input int flip);
      scfg_t c;
      c.en = 1; c.off = off; c.pay = p; c.flip = flip; c.bad_init = 0;
      return c;
   endfunction

   initial begin
      #2_000_000;
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      scfg_t a, b;
      logic [PAY_W-1:0] p1, p2;
      void'($urandom(32'd20230817));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "sync_trig", PAY_W'(sync_trig), '0);
      chk("R1", "frame_valid", PAY_W'(frame_valid), '0);
      chk("R1", "frame_bad", PAY_W'(frame_bad), '0);
      chk("R1", "payload", payload, '0);
      chk("R1", "sel_phase", PAY_W'(sel_phase), '0);
      rst_n = 1'b1;

      p1 = rnd_pay(); p2 = rnd_pay();
      // R6 R2: clean frame on both phases
      run_case("R6", mk(5, p1, -1), mk(5, p1, -1));
      // R7: B payload corrupted, A reported
      run_case("R7 A-only", mk(5, p2, -1), mk(5, p2, 100));
      // R7 R2: A payload corrupted, B reported
      run_case("R7 B-only", mk(6, p1, 60), mk(6, p1, -1));
      // R7: A sync broken, B alone after window
      run_case("R7 solo", mk(5, p2, 7), mk(5, p2, -1));
      // R9: both corrupted
      run_case("R9", mk(5, p1, 40), mk(5, p1, 150));
      // R8: both valid, different payloads
      run_case("R8", mk(5, p1, -1), mk(5, p2, -1));
      // R10: A 3 samples after B joins -> disagreement
      run_case("R10 join3", mk(7, p1, -1), mk(5, p2, -1));
      // R10: A 5 samples after B excluded -> B reported
      run_case("R10 excl5", mk(8, p1, -1), mk(5, p2, -1));
      // R10: B 3 samples after A joins
      run_case("R10 joinB", mk(5, p1, -1), mk(6, p2, -1));
      // R10: B 5 samples after A excluded -> A reported
      run_case("R10 exclB", mk(5, p1, -1), mk(7, p2, -1));
      // R11: no sync on either phase
      run_case("R11", mk(5, p1, 0), mk(5, p1, 31));
      // R4: pattern inside the payload does not restart capture
      p1 = {PAY_W'(PAT) << 60} | (rnd_pay() & ~({PAY_W'(32'hFFFF_FFFF)} << 60));
      run_case("R4", mk(4, p1, -1), mk(4, p1, -1));
      // R5: checksum corrupted on A only
      run_case("R5 crcfield", mk(5, p2, 190), mk(5, p2, -1));
      // R5: checksum built with start value 0 on both
      a = mk(5, p2, -1); a.bad_init = 1;
      b = mk(5, p2, -1); b.bad_init = 1;
      run_case("R5 init", a, b);
      // R5: start value 0 only on B -> A
      b = mk(5, p1, -1); b.bad_init = 1;
      run_case("R5 initB", mk(5, p1, -1), b);

      for (int t = 0; t < 25; t++) begin
         int r;
         a = mk(3 + int'($urandom() % 15), rnd_pay(), -1);
         b = mk(a.off + int'($urandom() % 7) - 3, ($urandom() % 3 == 0) ? rnd_pay() : a.pay, -1);
         r = int'($urandom() % 5);
         if (r == 1) a.flip = 32 + int'($urandom() % 168);
         if (r == 2) b.flip = int'($urandom() % 32);
         if (r == 3) b.flip = 32 + int'($urandom() % 168);
         if (r == 4) a.flip = int'($urandom() % 32);
         run_case("R6 R7 R8 R10 random", a, b);
      end

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule